// File: doc/BRIEF.md
# Sixteen-Bit Timer with Compare Outputs

This block is an up-counting timer with a 16-bit counter and two compare channels. Each channel drives its own output pin. The counter advances only on cycles where the prescaler tick is high. It runs in one of two ways:

- **Free-running:** the counter rolls over from 0xFFFF to 0x0000.
- **Clear-on-match:** the counter returns to zero after reaching a top value. The top value is taken either from compare register A or from a separate top register.

A sticky overflow flag records each rollover, so it extends the count by one bit. A match flag per channel records each compare hit. Software clears any flag by writing a 1 to its bit.

Each channel keeps an output register. When the counter meets that channel's compare value, a two-bit action code sets, clears or toggles the register, or leaves it alone. A force strobe applies the same action at once, without waiting for a match. The register can be preset while its pin is still disabled. A per-channel direction bit gates whether the pin shows the register. Writes to the counter, compare registers, top register, flags, output preset and direction bits all go through one simple write port.

Top module: `tmr16_compare_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the counter, all flags, the output registers and the direction bits. As a result, `count`, `ovf_flag`, `match_flag`, `pin_out` and `pin_oe` all read 0.
- R2: In mode 0 the counter behaves as follows:
  - It adds one on each cycle with `tick` high and holds on each cycle with `tick` low.
  - It rolls over from 0xFFFF to 0x0000.
  - It is never cleared by a compare hit.
- R3: `ovf_flag` is set on the tick that takes the counter from 0xFFFF to zero. It stays set until software writes a 1 to bit 0 at address 4. A set in the same cycle as that clear wins.
- R4: Mode 4 returns the counter to zero on the tick where it equals compare register A (address 1). Mode 12 does the same against the top register (address 3). Every other mode value behaves as mode 0.
- R5: A compare hit for channel i sets `match_flag[i]`. A hit is a tick where the counter equals compare register i (address 1+i). Writing a 1 to bit 1+i at address 4 clears the flag, and a hit in the same cycle wins.
- R6: On a hit for channel i, the action code `cmp_mode[2i+1:2i]` updates output register i as follows: 00 leaves it alone, 01 toggles it, 10 clears it, and 11 sets it.
- R7: Changing the action code between hits leaves the output register unchanged. The new code is used at the first hit after the change.
- R8: A high `force_cmp[i]` applies channel i's action at that edge, even with no tick. It sets no match flag and does not move the counter.
- R9: `pin_oe[i]` equals direction bit i (bit i at address 6). `pin_out[i]` equals output register i when that direction bit is 1 and the action code is nonzero; otherwise it is 0.
- R10: Writing address 5 loads output register i from data bit i, whether or not the pin is enabled. A hit or force in the same cycle takes priority over this preset.
- R11: A write to address 0 loads the counter in any mode and takes priority over a tick in the same cycle. The first tick after that write produces no compare hit and no clear-on-match for any channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 counter, 1-2 compare, 3 top, 4 flags, 5 output preset, 6 direction) |
| wr_data | input | 16 | Register write data |
| mode_sel | input | 4 | Counting mode (0 free-running, 4 clear at A, 12 clear at top register) |
| cmp_mode | input | 4 | Two-bit action code per channel |
| force_cmp | input | 2 | Force strobe per channel |
| count | output | 16 | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| match_flag | output | 2 | Sticky compare hit flag per channel |
| pin_out | output | 2 | Compare output pin value |
| pin_oe | output | 2 | Compare output pin direction |

## Verification
The checker watches these behaviours on every cycle:
- counter stepping and holding in mode 0;
- the overflow set at rollover and the flag staying set;
- the clear to zero at the top in mode 4;
- counter writes being loaded;
- pin gating by direction and action code;
- an output register staying unchanged under action code 00;
- a force never raising a match flag.

Some behaviours only the bench's scenarios can show, and it compares them against its own reference model:
- the exact toggle, set and clear results;
- a changed action code taking effect only at the next hit;
- preset before enable;
- the suppressed hit after a counter write;
- set-over-clear races on the flags.

// File: rtl/tmr16_pkg.sv
// Package: shared encodings for the compare timer.
// Assumes at most two compare channels, because the address map places
// the top register right after compare register B.
package tmr16_pkg;

    localparam logic [3:0] MODE_FREE    = 4'd0;
    localparam logic [3:0] MODE_CLR_A   = 4'd4;
    localparam logic [3:0] MODE_CLR_ALT = 4'd12;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } cmp_act_e;

    localparam logic [2:0] REG_COUNT   = 3'd0;
    localparam logic [2:0] REG_CMP0    = 3'd1;
    localparam logic [2:0] REG_TOP     = 3'd3;
    localparam logic [2:0] REG_FLAGS   = 3'd4;
    localparam logic [2:0] REG_PRESET  = 3'd5;
    localparam logic [2:0] REG_DIR     = 3'd6;

    // Returns the next output register value for a given action code.
    function automatic logic apply_act(input cmp_act_e act, input logic cur);
        case (act)
            ACT_TOGGLE: apply_act = ~cur;
            ACT_CLEAR:  apply_act = 1'b0;
            ACT_SET:    apply_act = 1'b1;
            default:    apply_act = cur;
        endcase
    endfunction

endpackage

// File: rtl/tmr16_counter.sv
// Counter core: counts up on tick, and in the two clear modes returns to
// zero at the selected top. It keeps the sticky overflow flag and the
// one-tick hit block that follows a software load of the counter.
// Assumes: a load beats a tick, and an overflow set beats its clear.
module tmr16_counter
    import tmr16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [3:0]       mode_sel,
    input  logic [WIDTH-1:0] top_a,
    input  logic [WIDTH-1:0] top_alt,
    input  logic             ovf_clr,
    output logic [WIDTH-1:0] count,
    output logic             ovf_flag,
    output logic             blk
);
    localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};

    logic [WIDTH-1:0] count_q;
    logic [WIDTH-1:0] top_sel;
    logic             is_clr_mode;
    logic             at_top;
    logic             ovf_q;
    logic             blk_q;

    // Select the top value and decide whether this tick clears the counter.
    always_comb begin
        top_sel     = (mode_sel == MODE_CLR_ALT) ? top_alt : top_a;
        is_clr_mode = (mode_sel == MODE_CLR_A) || (mode_sel == MODE_CLR_ALT);
        at_top      = is_clr_mode && !blk_q && (count_q == top_sel);
    end

    // Counter register: a software load first, then the tick step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (cnt_wr)
            count_q <= wr_data;
        else if (tick)
            count_q <= at_top ? '0 : count_q + 1'b1;
    end

    // Overflow flag: set at rollover, cleared by software write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (tick && !cnt_wr && (count_q == FULL))
            ovf_q <= 1'b1;
        else if (ovf_clr)
            ovf_q <= 1'b0;
    end

    // Hit block: armed by a counter load, released by the next tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            blk_q <= 1'b0;
        else if (cnt_wr)
            blk_q <= 1'b1;
        else if (tick)
            blk_q <= 1'b0;
    end

    assign count    = count_q;
    assign ovf_flag = ovf_q;
    assign blk      = blk_q;

endmodule

// File: rtl/tmr16_cmp_chan.sv
// One compare channel: detects a hit, keeps the sticky match flag and the
// output register, and gates the pin.
// Assumes: the caller supplies the hit block and the counter-load strobe.
// Priority on the output register is hit or force first, then preset.
module tmr16_cmp_chan
    import tmr16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic             blk,
    input  logic [WIDTH-1:0] count,
    input  logic [WIDTH-1:0] cmp_val,
    input  logic [1:0]       act,
    input  logic             force_i,
    input  logic             preset_wr,
    input  logic             preset_val,
    input  logic             flag_clr,
    input  logic             oe,
    output logic             match_flag,
    output logic             oreg,
    output logic             pin_out
);
    logic hit;
    logic do_act;
    logic flag_q;
    logic oreg_q;

    // Hit detection and the combined action request.
    always_comb begin
        hit    = tick && !cnt_wr && !blk && (count == cmp_val);
        do_act = hit || force_i;
    end

    // Match flag: set by a hit, cleared by software write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (hit)
            flag_q <= 1'b1;
        else if (flag_clr)
            flag_q <= 1'b0;
    end

    // Output register: the compare action beats a software preset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            oreg_q <= 1'b0;
        else if (do_act)
            oreg_q <= apply_act(cmp_act_e'(act), oreg_q);
        else if (preset_wr)
            oreg_q <= preset_val;
    end

    assign match_flag = flag_q;
    assign oreg       = oreg_q;
    assign pin_out    = oe && (act != ACT_NONE) && oreg_q;

endmodule

// File: rtl/tmr16_compare_timer.sv
// Top level: holds the write-port registers (compare values, top value,
// direction bits), decodes writes, and builds the counter and channels.
// Assumes: NUM_CH is at most 2 (compare registers sit at 1..NUM_CH).
module tmr16_compare_timer
    import tmr16_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int NUM_CH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [WIDTH-1:0]    wr_data,
    input  logic [3:0]          mode_sel,
    input  logic [2*NUM_CH-1:0] cmp_mode,
    input  logic [NUM_CH-1:0]   force_cmp,
    output logic [WIDTH-1:0]    count,
    output logic                ovf_flag,
    output logic [NUM_CH-1:0]   match_flag,
    output logic [NUM_CH-1:0]   pin_out,
    output logic [NUM_CH-1:0]   pin_oe
);
    logic [NUM_CH-1:0][WIDTH-1:0] cmp_q;
    logic [WIDTH-1:0]             top_q;
    logic [NUM_CH-1:0]            dir_q;
    logic [NUM_CH-1:0]            oreg;
    logic                         cnt_wr;
    logic                         flag_wr;
    logic                         preset_wr;
    logic                         blk;

    // Write decode for the strobes that the submodules consume.
    always_comb begin
        cnt_wr    = wr_en && (wr_addr == REG_COUNT);
        flag_wr   = wr_en && (wr_addr == REG_FLAGS);
        preset_wr = wr_en && (wr_addr == REG_PRESET);
    end

    // Compare, top and direction registers loaded from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
            top_q <= '0;
            dir_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_CH; i++)
                if (wr_addr == REG_CMP0 + 3'(i))
                    cmp_q[i] <= wr_data;
            if (wr_addr == REG_TOP)
                top_q <= wr_data;
            if (wr_addr == REG_DIR)
                dir_q <= wr_data[NUM_CH-1:0];
        end
    end

    tmr16_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cnt_wr   (cnt_wr),
        .wr_data  (wr_data),
        .mode_sel (mode_sel),
        .top_a    (cmp_q[0]),
        .top_alt  (top_q),
        .ovf_clr  (flag_wr && wr_data[0]),
        .count    (count),
        .ovf_flag (ovf_flag),
        .blk      (blk)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tmr16_cmp_chan #(.WIDTH(WIDTH)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .cnt_wr     (cnt_wr),
            .blk        (blk),
            .count      (count),
            .cmp_val    (cmp_q[g]),
            .act        (cmp_mode[2*g +: 2]),
            .force_i    (force_cmp[g]),
            .preset_wr  (preset_wr),
            .preset_val (wr_data[g]),
            .flag_clr   (flag_wr && wr_data[g+1]),
            .oe         (dir_q[g]),
            .match_flag (match_flag[g]),
            .oreg       (oreg[g]),
            .pin_out    (pin_out[g])
        );
    end

    assign pin_oe = dir_q;

endmodule

// File: rtl/tmr16_timer_chk.sv
// Checker for the compare timer, bound into every instance of the top.
// It watches ports and a few internal signals (compare values, hit block,
// output registers) that separate pieces of logic drive.
module tmr16_timer_chk #(
    parameter int WIDTH  = 16,
    parameter int NUM_CH = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         tick,
    input logic                         wr_en,
    input logic [2:0]                   wr_addr,
    input logic [WIDTH-1:0]             wr_data,
    input logic [3:0]                   mode_sel,
    input logic [2*NUM_CH-1:0]          cmp_mode,
    input logic [NUM_CH-1:0]            force_cmp,
    input logic [WIDTH-1:0]             count,
    input logic                         ovf_flag,
    input logic [NUM_CH-1:0]            match_flag,
    input logic [NUM_CH-1:0]            pin_out,
    input logic [NUM_CH-1:0]            pin_oe,
    input logic [NUM_CH-1:0][WIDTH-1:0] cmp_q,
    input logic                         blk,
    input logic [NUM_CH-1:0]            oreg
);
    logic ld;
    logic ovf_wclr;
    assign ld       = wr_en && (wr_addr == 3'd0);
    assign ovf_wclr = wr_en && (wr_addr == 3'd4) && wr_data[0];

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (count == '0) && !ovf_flag && (match_flag == '0) && (pin_oe == '0));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && mode_sel == 4'd0) |=> count == $past(count) + 1'b1);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld) |=> $stable(count));

    assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && count == {WIDTH{1'b1}}) |=> (ovf_flag && count == '0));

    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_wclr) |=> ovf_flag);

    assert_clr_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && !blk && mode_sel == 4'd4 && count == cmp_q[0]) |=> count == '0);

    assert_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> count == $past(wr_data));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        assert_pin_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
            pin_out[g] |-> (pin_oe[g] && cmp_mode[2*g +: 2] != 2'b00));

        assert_act_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_mode[2*g +: 2] == 2'b00 && !(wr_en && wr_addr == 3'd5))
            |=> oreg[g] == $past(oreg[g]));

        assert_force_noflag_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (force_cmp[g] && !match_flag[g]
             && !(tick && !ld && !blk && count == cmp_q[g])) |=> !match_flag[g]);
    end

endmodule

bind tmr16_compare_timer tmr16_timer_chk #(.WIDTH(WIDTH), .NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .mode_sel   (mode_sel),
    .cmp_mode   (cmp_mode),
    .force_cmp  (force_cmp),
    .count      (count),
    .ovf_flag   (ovf_flag),
    .match_flag (match_flag),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .cmp_q      (cmp_q),
    .blk        (blk),
    .oreg       (oreg)
);

// File: tb/sim_tmr16_compare_timer.sv
`timescale 1ns/1ps
module sim_tmr16_compare_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [15:0] wr_data = 16'd0;
    logic [3:0]  mode_sel = 4'd0;
    logic [3:0]  cmp_mode = 4'd0;
    logic [1:0]  force_cmp = 2'b00;
    logic [15:0] count;
    logic        ovf_flag;
    logic [1:0]  match_flag;
    logic [1:0]  pin_out;
    logic [1:0]  pin_oe;

    // Reference model state
    logic [15:0] m_cnt;
    logic        m_ovf;
    logic [1:0]  m_flag;
    logic [1:0]  m_oreg;
    logic        m_blk;
    logic [15:0] m_cmp [2];
    logic [15:0] m_top;
    logic [1:0]  m_dir;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    tmr16_compare_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode_sel(mode_sel), .cmp_mode(cmp_mode),
        .force_cmp(force_cmp), .count(count), .ovf_flag(ovf_flag),
        .match_flag(match_flag), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Next output register value for an action code.
    function automatic logic act_next(input logic [1:0] a, input logic cur);
        case (a)
            2'b01: return ~cur;
            2'b10: return 1'b0;
            2'b11: return 1'b1;
            default: return cur;
        endcase
    endfunction

    // Expected pin value from the requirements.
    function automatic logic exp_pin(input int i);
        return m_dir[i] && (cmp_mode[2*i +: 2] != 2'b00) && m_oreg[i];
    endfunction

    task automatic model_reset();
        m_cnt = '0; m_ovf = 0; m_flag = '0; m_oreg = '0; m_blk = 0;
        m_cmp[0] = '0; m_cmp[1] = '0; m_top = '0; m_dir = '0;
    endtask

    // Advance the model by one clock using the inputs driven this cycle.
    task automatic model_step();
        logic        ld;
        logic        clr_mode;
        logic [15:0] top;
        logic [1:0]  hit;
        ld       = wr_en && wr_addr == 3'd0;
        clr_mode = (mode_sel == 4'd4) || (mode_sel == 4'd12);
        top      = (mode_sel == 4'd12) ? m_top : m_cmp[0];
        for (int i = 0; i < 2; i++)
            hit[i] = tick && !ld && !m_blk && (m_cnt == m_cmp[i]);
        for (int i = 0; i < 2; i++) begin
            if (hit[i]) m_flag[i] = 1'b1;
            else if (wr_en && wr_addr == 3'd4 && wr_data[i+1]) m_flag[i] = 1'b0;
            if (hit[i] || force_cmp[i]) m_oreg[i] = act_next(cmp_mode[2*i +: 2], m_oreg[i]);
            else if (wr_en && wr_addr == 3'd5) m_oreg[i] = wr_data[i];
        end
        if (tick && !ld && m_cnt == 16'hFFFF) m_ovf = 1'b1;
        else if (wr_en && wr_addr == 3'd4 && wr_data[0]) m_ovf = 1'b0;
        if (ld) m_cnt = wr_data;
        else if (tick) m_cnt = (clr_mode && !m_blk && m_cnt == top) ? 16'd0 : m_cnt + 16'd1;
        if (ld) m_blk = 1'b1;
        else if (tick) m_blk = 1'b0;
        if (wr_en) begin
            if (wr_addr == 3'd1) m_cmp[0] = wr_data;
            if (wr_addr == 3'd2) m_cmp[1] = wr_data;
            if (wr_addr == 3'd3) m_top = wr_data;
            if (wr_addr == 3'd6) m_dir = wr_data[1:0];
        end
    endtask

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        check("count", 32'(count), 32'(m_cnt));
        check("ovf_flag", 32'(ovf_flag), 32'(m_ovf));
        check("match_flag", 32'(match_flag), 32'(m_flag));
        check("pin_oe", 32'(pin_oe), 32'(m_dir));
        check("pin_out", 32'(pin_out), 32'({exp_pin(1), exp_pin(0)}));
    endtask

    // One clock: edge, model update, then compare at the falling edge.
    task automatic cyc();
        @(posedge clk);
        if (rst_n) model_step(); else model_reset();
        @(negedge clk);
        check_all();
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20250611);
        model_reset();
        @(negedge clk);
        cur_req = "R1";
        run(3);
        rst_n = 1'b1;
        cyc();

        cur_req = "R2";
        mode_sel = 4'd0; tick = 1'b1;
        run(10);
        tick = 1'b0; run(4);
        check("R2 count after ten ticks", 32'(count), 32'd10);
        wr(3'd1, 16'd3);
        tick = 1'b1; run(12);

        cur_req = "R11";
        wr(3'd0, 16'hFFFD);
        cur_req = "R3";
        run(5);
        check("R3 overflow after rollover", 32'(ovf_flag), 32'd1);
        tick = 1'b0; run(2);
        wr(3'd4, 16'h0001);
        check("R3 overflow cleared", 32'(ovf_flag), 32'd0);
        tick = 1'b0; wr(3'd0, 16'hFFFF);
        tick = 1'b1; cyc();
        wr(3'd4, 16'h0001);
        tick = 1'b1; wr(3'd0, 16'hFFFF); tick = 1'b0; cyc();
        tick = 1'b1; wr(3'd4, 16'h0001);
        check("R3 set beats clear", 32'(ovf_flag), 32'd1);
        tick = 1'b0; wr(3'd4, 16'h0007);

        cur_req = "R4";
        wr(3'd1, 16'd5); wr(3'd0, 16'd0);
        mode_sel = 4'd4; tick = 1'b1; run(20);
        wr(3'd3, 16'd3); mode_sel = 4'd12; run(15);
        mode_sel = 4'd7; wr(3'd0, 16'd2); run(8);
        check("R4 unsupported mode free-runs", 32'(count), 32'd10);

        cur_req = "R5";
        mode_sel = 4'd4; wr(3'd2, 16'd2); wr(3'd6, 16'h0003);
        cmp_mode = 4'b1101; run(14);
        cur_req = "R6";
        cmp_mode = 4'b1001; run(14);
        tick = 1'b0; wr(3'd4, 16'h0006);

        cur_req = "R7";
        wr(3'd0, 16'd0);
        cmp_mode = 4'b0111; cyc();
        cmp_mode = 4'b1011; cyc();
        tick = 1'b1; run(7);

        cur_req = "R8";
        tick = 1'b0; cmp_mode = 4'b0101; wr(3'd4, 16'h0006);
        force_cmp = 2'b11; cyc(); force_cmp = 2'b00; cyc();
        check("R8 force sets no flag", 32'(match_flag), 32'd0);

        cur_req = "R9";
        wr(3'd6, 16'h0001); run(2);
        cmp_mode = 4'b0100; cyc();

        cur_req = "R10";
        wr(3'd6, 16'h0000); wr(3'd5, 16'h0003);
        check("R10 pin hidden while disabled", 32'(pin_out), 32'd0);
        cmp_mode = 4'b1111; wr(3'd6, 16'h0003);
        check("R10 preset visible", 32'(pin_out), 32'd3);
        force_cmp = 2'b01; cmp_mode = 4'b1010; wr(3'd5, 16'h0003); force_cmp = 2'b00;
        cyc();

        cur_req = "R11";
        mode_sel = 4'd4; wr(3'd4, 16'h0007);
        wr(3'd0, 16'd5);
        tick = 1'b1; cyc();
        check("R11 no clear after load", 32'(count), 32'd6);
        check("R11 no hit after load", 32'(match_flag[0]), 32'd0);
        tick = 1'b0; cyc();

        cur_req = "R6";
        for (int k = 0; k < 4000; k++) begin
            logic [3:0] r;
            tick = ($urandom % 4) != 0;
            force_cmp = (($urandom % 16) == 0) ? 2'($urandom) : 2'b00;
            if (($urandom % 32) == 0) cmp_mode = 4'($urandom);
            if (($urandom % 200) == 0) begin
                r = 4'($urandom % 4);
                mode_sel = (r == 0) ? 4'd0 : (r == 1) ? 4'd4 : (r == 2) ? 4'd12 : 4'd9;
            end
            if (($urandom % 10) == 0) begin
                wr_en = 1'b1;
                wr_addr = 3'($urandom % 7);
                wr_data = (wr_addr == 3'd0 && ($urandom % 4) == 0)
                          ? 16'hFFF0 + 16'($urandom % 16) : 16'($urandom % 24);
                if (wr_addr == 3'd4) wr_data = 16'($urandom % 8);
            end
            cyc();
            wr_en = 1'b0;
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule